// File: doc/BRIEF.md
# Floating-Point Status Flags and Exception Trap Logic

This block holds the floating-point status and control word that sits beside an arithmetic unit. Software loads the word through a write port and reads it back at any time. The arithmetic unit reports each finished operation with five raw exception bits. From those bits the block rewrites the per-operation flag field. It ORs the same bits into a cause field that keeps accumulating. When an accumulated cause meets a set enable bit, the block raises a trap request that carries a fixed vector code.

The block also decodes two control settings from the word and drives them back to the datapath: truncation versus round-to-nearest-even, and flush-to-zero for denormals. The operation report is a valid/ready stream. `op_valid` with `op_exc` offers a report, and the block accepts it on a clock edge where `op_ready` is also high. `op_ready` falls in any cycle where a software write is presented, so a write always wins. The producer must then hold `op_valid` and `op_exc` until a cycle without a write. All other pins are plain levels.

Word layout:

| Bits | Field |
|---|---|
| 1:0 | rounding mode |
| 6:2 | flags |
| 11:7 | enables |
| 17:12 | cause |
| 18 | denormal control |
| 31:19 | read as zero |

Inside each 5-bit group, bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. `op_exc` uses the same order.

Top module: `fpsc_top`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `csr_rdata` is 0, `trap_req` is 0, `trap_code` is 0, `round_to_zero` is 0 and `flush_to_zero` is 0.
- R2: A write (`csr_wr_en` high at a clock edge) makes `csr_rdata` equal `csr_wr_data & 32'h0007_FFFF` from the next cycle on, so bits 31:19 always read 0.
- R3: `round_to_zero` is 1 exactly when bits 1:0 of the word equal 1. The values 0, 2 and 3 give 0, which means round-to-nearest-even.
- R4: `flush_to_zero` equals bit 18 of the word.
- R5: When a report is accepted, bits 6:2 of the word are replaced by `op_exc` in the next cycle. An all-zero report therefore clears them.
- R6: When an accepted report is nonzero, bits 16:12 become their old value ORed with `op_exc`. When it is zero, the cause field is unchanged. Bit 17 is never changed by a report.
- R7: `trap_req` is high for exactly the one cycle after an accepted report. This happens only if the report is nonzero and the updated bits 16:12 ANDed with bits 11:7 is nonzero. `trap_code` is 12'h120 while `trap_req` is high and 0 otherwise.
- R8: `op_ready` is the inverse of `csr_wr_en`. In a cycle with a write, no report is accepted, no trap is raised, and the written value alone lands.
- R9: An accepted report leaves bits 1:0, 11:7, 18 and 31:19 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Software write strobe |
| csr_wr_data | input | 32 | Value to write |
| csr_rdata | output | 32 | Current status/control word |
| op_valid | input | 1 | Operation report offered |
| op_ready | output | 1 | Report can be accepted this cycle |
| op_exc | input | 5 | Raw exceptions of the operation {V,Z,O,U,I} |
| round_to_zero | output | 1 | Datapath truncates when high |
| flush_to_zero | output | 1 | Datapath flushes denormals when high |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Vector code of the trap, 0 when idle |

## Verification
The flag and cause paths are driven with single-bit, multi-bit, all-ones and all-zero exception reports. Comparing the two fields after each report shows whether a field is overwritten or accumulated. The enable mask is then set so that it overlaps only with a cause bit from an earlier report. This shows that the trap decision uses the accumulated cause and not the current flags, and that a zero report cannot trap even when a stale cause is enabled. Each clock, a behavioural reference model is compared with the readback, trap and control outputs. The runs include reports that collide with writes, all four rounding values, and writes that try to set the read-as-zero bits.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

  localparam int EXC_N     = 5;
  localparam int CSR_W     = 32;
  localparam int CAUSE_W   = EXC_N + 1;
  localparam int RM_W      = 2;
  localparam int PAD_W     = CSR_W - RM_W - 2*EXC_N - CAUSE_W - 1;
  localparam logic [CSR_W-1:0] WR_MASK = 32'h0007_FFFF;
  localparam logic [RM_W-1:0]  RM_TRUNC = 2'd1;

  typedef logic [EXC_N-1:0] exc_t;

  typedef struct packed {
    logic [PAD_W-1:0]   pad;
    logic               dn;
    logic [CAUSE_W-1:0] cause;
    exc_t               en;
    exc_t               flags;
    logic [RM_W-1:0]    rm;
  } csr_t;

endpackage

// File: rtl/fpsc_exc_merge.sv
module fpsc_exc_merge
  import fpsc_pkg::*;
(
  input  csr_t cur,
  input  exc_t exc,
  output csr_t nxt,
  output logic trap_hit
);
  localparam int N = EXC_N;

  logic       any_exc;
  logic [N-1:0] cause_or;
  logic [N-1:0] hit;

  assign any_exc = |exc;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      assign cause_or[g] = cur.cause[g] | exc[g];
      assign hit[g]      = cause_or[g] & cur.en[g];
    end
  endgenerate

  always_comb begin
    nxt       = cur;
    nxt.flags = exc;
    trap_hit  = 1'b0;
    if (any_exc) begin
      nxt.cause[N-1:0] = cause_or;
      trap_hit         = |hit;
    end
  end
endmodule

// File: rtl/fpsc_mode_decode.sv
module fpsc_mode_decode
  import fpsc_pkg::*;
(
  input  csr_t word,
  output logic round_to_zero,
  output logic flush_to_zero
);
  assign round_to_zero = (word.rm == RM_TRUNC);
  assign flush_to_zero = word.dn;
endmodule

// File: rtl/fpsc_top.sv
module fpsc_top
  import fpsc_pkg::*;
#(
  parameter int              VEC_W    = 12,
  parameter logic [VEC_W-1:0] TRAP_VEC = 12'h120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr_en,
  input  logic [31:0]      csr_wr_data,
  output logic [31:0]      csr_rdata,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [4:0]       op_exc,
  output logic             round_to_zero,
  output logic             flush_to_zero,
  output logic             trap_req,
  output logic [VEC_W-1:0] trap_code
);
  csr_t csr_q;
  csr_t csr_merged;
  logic trap_hit;
  logic trap_q;
  logic accept;

  assign op_ready = !csr_wr_en;
  assign accept   = op_valid && op_ready;

  fpsc_exc_merge u_merge (
    .cur      (csr_q),
    .exc      (op_exc),
    .nxt      (csr_merged),
    .trap_hit (trap_hit)
  );

  fpsc_mode_decode u_mode (
    .word          (csr_q),
    .round_to_zero (round_to_zero),
    .flush_to_zero (flush_to_zero)
  );

  // write first; a report waits while a write is presented
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= accept && trap_hit;
      if (csr_wr_en)   csr_q <= csr_t'(csr_wr_data & WR_MASK);
      else if (accept) csr_q <= csr_merged;
    end
  end

  assign csr_rdata = csr_q;
  assign trap_req  = trap_q;
  assign trap_code = trap_q ? TRAP_VEC : '0;
endmodule

// File: rtl/fpsc_chk.sv
module fpsc_chk #(
  parameter int VEC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_wr_en,
  input logic [31:0]      csr_wr_data,
  input logic [31:0]      csr_rdata,
  input logic             op_valid,
  input logic             op_ready,
  input logic [4:0]       op_exc,
  input logic             round_to_zero,
  input logic             flush_to_zero,
  input logic             trap_req,
  input logic [VEC_W-1:0] trap_code
);
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en |=> csr_rdata == ($past(csr_wr_data) & 32'h0007_FFFF)); // R2
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[31:19] == '0); // R2
  AST_RTZ_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    round_to_zero == (csr_rdata[1:0] == 2'd1)); // R3
  AST_FTZ_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_to_zero == csr_rdata[18]); // R4
  AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> csr_rdata[6:2] == $past(op_exc)); // R5
  AST_CAUSE_B17: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr_en |=> $stable(csr_rdata[17])); // R6
  AST_TRAP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(op_valid && op_ready && (op_exc != '0))); // R7
  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req || $past(op_valid && op_ready)); // R7
  AST_TRAP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_code == (trap_req ? 12'h120 : 12'h000)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en |-> !op_ready); // R8
  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr_en |=> $stable(csr_rdata[11:7]) && $stable(csr_rdata[1:0])
                   && $stable(csr_rdata[18])); // R9
endmodule

bind fpsc_top fpsc_chk #(.VEC_W(VEC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .csr_wr_en     (csr_wr_en),
  .csr_wr_data   (csr_wr_data),
  .csr_rdata     (csr_rdata),
  .op_valid      (op_valid),
  .op_ready      (op_ready),
  .op_exc        (op_exc),
  .round_to_zero (round_to_zero),
  .flush_to_zero (flush_to_zero),
  .trap_req      (trap_req),
  .trap_code     (trap_code)
);

// File: tb/fpsc_top_tb.sv
`timescale 1ns/1ps
module fpsc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_en = 1'b0;
  logic [31:0] csr_wr_data = '0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_exc = '0;
  logic [31:0] csr_rdata;
  logic        op_ready, round_to_zero, flush_to_zero, trap_req;
  logic [11:0] trap_code;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  int unsigned m_csr = 0;
  bit          m_trap = 0;

  always #5 clk = ~clk;

  fpsc_top u_dut (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
    .csr_rdata(csr_rdata), .op_valid(op_valid), .op_ready(op_ready), .op_exc(op_exc),
    .round_to_zero(round_to_zero), .flush_to_zero(flush_to_zero),
    .trap_req(trap_req), .trap_code(trap_code)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int unsigned rm;
    rm = m_csr & 3;
    check(tag,  "csr_rdata",     csr_rdata, m_csr);
    check("R7", "trap_req",      {31'd0, trap_req}, {31'd0, m_trap});
    check("R7", "trap_code",     {20'd0, trap_code}, m_trap ? 32'h120 : 32'h0);
    check("R3", "round_to_zero", {31'd0, round_to_zero}, (rm == 1) ? 32'd1 : 32'd0);
    check("R4", "flush_to_zero", {31'd0, flush_to_zero}, (m_csr >> 18) & 1);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input bit wr, input logic [31:0] wd,
                      input bit vld, input logic [4:0] ex);
    int unsigned c, e, x;
    csr_wr_en = wr; csr_wr_data = wd; op_valid = vld; op_exc = ex;
    #1;
    check("R8", "op_ready", {31'd0, op_ready}, wr ? 32'd0 : 32'd1);
    @(posedge clk);
    x = ex;
    if (wr) begin
      m_csr = wd & 32'h0007_FFFF; m_trap = 0;
    end else if (vld) begin
      m_csr = (m_csr & ~(32'h1F << 2)) | (x << 2);
      m_trap = 0;
      if (x != 0) begin
        m_csr = m_csr | (x << 12);
        c = (m_csr >> 12) & 31;
        e = (m_csr >> 7) & 31;
        m_trap = (c & e) != 0;
      end
    end else m_trap = 0;
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R2 masking, R3 / R4 decode
    step("R2", 1, 32'hFFFF_FFFF, 0, 5'h00);
    step("R2", 1, 32'h0004_0001, 0, 5'h00);
    step("R3", 1, 32'h0000_0002, 0, 5'h00);
    step("R3", 1, 32'h0000_0003, 0, 5'h00);
    step("R3", 1, 32'h0000_0000, 0, 5'h00);

    // enables off: flags overwrite, cause accumulates, no trap (R5 R6)
    step("R5", 0, 0, 1, 5'b00001);
    step("R6", 0, 0, 1, 5'b01000);
    step("R5", 0, 0, 1, 5'b00000);
    step("R6", 0, 0, 1, 5'b11111);
    step("R6", 0, 0, 0, 5'b10101);

    // enable only V; cause I only -> no trap, then V -> trap
    step("R2", 1, 32'h0000_0800, 0, 5'h00);
    step("R7", 0, 0, 1, 5'b00001);
    step("R7", 0, 0, 1, 5'b00100);
    step("R7", 0, 0, 1, 5'b10000);
    step("R7", 0, 0, 0, 5'b00000);
    // stale enabled cause + zero report -> no trap; + unrelated report -> trap
    step("R7", 0, 0, 1, 5'b00000);
    step("R7", 0, 0, 1, 5'b00010);

    // controls kept, cause bit 17 kept (R9 R6)
    step("R9", 1, 32'h0006_0F81, 0, 5'h00);
    step("R9", 0, 0, 1, 5'b01100);
    step("R9", 0, 0, 1, 5'b00011);

    // write collides with a report (R8)
    step("R8", 1, 32'h0000_0880, 1, 5'b11111);
    step("R8", 0, 0, 1, 5'b00010);

    // sweep of patterns
    for (int i = 0; i < 60; i++) begin
      if (i % 10 == 0)
        step("R2", 1, (i * 32'h0001_3579) ^ 32'h0004_0F80, 0, 5'h00);
      else
        step("R6", (i % 7) == 3, 32'h0000_0180 | i, (i % 4) != 1, 5'((i * 11 + 3) % 32));
    end

    // reset mid-run (R1)
    csr_wr_en = 0; op_valid = 0; rst_n = 1'b0;
    m_csr = 0; m_trap = 0;
    @(negedge clk);
    @(negedge clk);
    compare_all("R1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule